// File: doc/BRIEF.md
# PCI Type-0 Configuration Header Register File

This block holds the standard 64-byte configuration header of one PCI device function and answers configuration accesses to it. An access presents a byte offset, a byte count of 1, 2 or 4, write data aligned to bit 0 and a write strobe. Read data comes back combinationally, little-endian and zero-extended to 32 bits. Offsets at or above 0x40 are not handled here: they are passed to a device-specific port together with an offset that is rebased to zero, and that port's read data is returned unchanged.

Only a few header fields can be written, and each only at one access width. The interrupt line, cache line size and latency timer take single-byte writes. Command and status take two-byte writes. The six base address registers take aligned four-byte writes. Writing all ones to a base address register returns its size mask on the next read, which is how software discovers the size of the window. Each window size is a power-of-two parameter. The low type bits are read-only: two bits for an I/O register (stored bit 0 set) and four bits for a memory register. Every write that is not taken raises a one-cycle flag and leaves every register as it was.

Top module: `cfg_header_regs`

## Requirements
- R1: After reset, dword 0x00 reads {DEVICE_ID, VENDOR_ID}, 0x08 reads {CLASS_CODE, REVISION}, byte 0x0E reads HDR_TYPE, bytes 0x3D/0x3E/0x3F read INT_PIN/MIN_GNT/MAX_LAT, command, status, interrupt line (0x3C), cache line size (0x0C) and latency timer (0x0D) read zero, and each base address register at 0x10+4*n reads 1 if it is an I/O register and 0 otherwise. Every other header byte reads zero.
- R2: A read with size 1, 2 or 4 returns header bytes offset..offset+size-1, with the lowest offset in bits 7:0, zero-extended to 32 bits. Bytes at or beyond 0x40 read as zero. For any other size, rd_bad_size is high and a header read returns zero.
- R3: When the offset is 0x40 or above, dev_wr follows cfg_wr, dev_offset is offset minus 0x40, rdata equals dev_rdata, no header register changes and wr_nack stays low.
- R4: A 1-byte write at 0x3C, 0x0C or 0x0D stores cfg_wdata[7:0] in that byte.
- R5: A 1-byte write to a read-only byte (interrupt pin, minimum grant, maximum latency, class code, revision or any other byte except those in R4) changes nothing and is flagged.
- R6: A 2-byte write at 0x04 stores cfg_wdata[15:0] as command, and one at 0x06 stores it as status.
- R7: An aligned 4-byte write of 0xFFFFFFFF to a base address register stores ~(SIZE-1) with the low read-only bits cleared, and keeps the stored low bits (bits 1:0 for I/O, bits 3:0 for memory).
- R8: Any other aligned 4-byte write to a base address register stores the written value with the same low read-only bits kept from the stored value.
- R9: A write with a size other than 1, 2 or 4 (including 3) is rejected: it is flagged and changes nothing.
- R10: A write whose width is not the one accepted at that offset (for example 4 bytes at 0x04, 2 bytes at 0x3C, or 4 bytes at 0x12) is rejected: it is flagged and changes nothing.
- R11: A base address register whose size parameter is zero always reads zero, and writes to it are flagged.
- R12: wr_nack is high for exactly the one cycle after a flagged write and low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_offset | input | OFF_W | Byte offset of the access |
| cfg_size | input | 3 | Access width in bytes |
| cfg_wdata | input | 32 | Write data, aligned to bit 0 |
| cfg_wr | input | 1 | Write strobe, one access per asserted cycle |
| rdata | output | 32 | Read data for the present offset and size |
| rd_bad_size | output | 1 | Present size is not 1, 2 or 4 |
| wr_nack | output | 1 | One-cycle flag for a rejected or ignored write |
| dev_wr | output | 1 | Write strobe to the device-specific region |
| dev_offset | output | OFF_W | Offset rebased to the device-specific region |
| dev_rdata | input | 32 | Read data from the device-specific region |

## Verification
The hardest state to reach from the ports is a base address register whose high bits hold a size mask while its low type bits are still intact. Reaching it takes an all-ones write on exactly an aligned register offset, followed by ordinary writes that try to flip the protected bits. The stimulus mixes directed sizing and overwrite sequences on I/O, memory and zero-size registers with a random stream. In that stream about a quarter of the write values are all ones, and the offsets cluster in the header, so sizing, overwrite and rejection interleave. Every write is followed by a random-width read that is compared with a bench model of the header.

// File: rtl/cfg_hdr_pkg.sv
package cfg_hdr_pkg;

  localparam int NUM_BARS  = 6;
  localparam int HDR_END   = 'h40;
  localparam int HDR_DW    = HDR_END / 4;

  localparam int OFF_CMD   = 'h04;
  localparam int OFF_STAT  = 'h06;
  localparam int OFF_CLS   = 'h0C;
  localparam int OFF_LAT   = 'h0D;
  localparam int OFF_BAR0  = 'h10;
  localparam int OFF_ILINE = 'h3C;

  localparam logic [2:0] SZ_BYTE = 3'd1;
  localparam logic [2:0] SZ_HALF = 3'd2;
  localparam logic [2:0] SZ_WORD = 3'd4;

  typedef struct packed {
    logic                cmd;
    logic                stat;
    logic                iline;
    logic                cls;
    logic                lat;
    logic [NUM_BARS-1:0] bar;
    logic                nack;
  } wr_dec_t;

  function automatic logic [NUM_BARS-1:0] bar_live(input logic [NUM_BARS*32-1:0] sizes);
    logic [NUM_BARS-1:0] v;
    for (int b = 0; b < NUM_BARS; b++) v[b] = (sizes[b*32 +: 32] != 32'h0);
    return v;
  endfunction

endpackage

// File: rtl/cfg_wr_decode.sv
module cfg_wr_decode
  import cfg_hdr_pkg::*;
#(
  parameter int                  OFF_W    = 8,
  parameter logic [NUM_BARS-1:0] BAR_LIVE = '1
) (
  input  logic [OFF_W-1:0] off,
  input  logic [2:0]       size,
  input  logic             wr,
  output wr_dec_t          dec
);

  logic in_hdr;
  logic bar_hit;

  assign in_hdr = (off < OFF_W'(HDR_END));

  always_comb begin
    dec     = '0;
    bar_hit = 1'b0;
    if (wr && in_hdr) begin
      case (size)
        SZ_BYTE: begin
          if (off == OFF_W'(OFF_ILINE))    dec.iline = 1'b1;
          else if (off == OFF_W'(OFF_CLS)) dec.cls   = 1'b1;
          else if (off == OFF_W'(OFF_LAT)) dec.lat   = 1'b1;
          else                             dec.nack  = 1'b1;
        end
        SZ_HALF: begin
          if (off == OFF_W'(OFF_CMD))       dec.cmd  = 1'b1;
          else if (off == OFF_W'(OFF_STAT)) dec.stat = 1'b1;
          else                              dec.nack = 1'b1;
        end
        SZ_WORD: begin
          for (int b = 0; b < NUM_BARS; b++) begin
            if (off == OFF_W'(OFF_BAR0 + 4 * b)) begin
              bar_hit = 1'b1;
              if (BAR_LIVE[b]) dec.bar[b] = 1'b1;
              else             dec.nack   = 1'b1;
            end
          end
          if (!bar_hit) dec.nack = 1'b1;
        end
        default: dec.nack = 1'b1;
      endcase
    end
  end

endmodule

// File: rtl/cfg_bar_slot.sv
module cfg_bar_slot #(
  parameter logic [31:0] SIZE  = 32'h1000,
  parameter bit          IS_IO = 1'b0
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wdata,
  output logic [31:0] q
);

  localparam logic [31:0] LOWM  = IS_IO ? 32'h3 : 32'hF;
  localparam logic [31:0] SMASK = ~(SIZE - 32'h1) & ~LOWM;
  localparam logic [31:0] RSTV  = IS_IO ? 32'h1 : 32'h0;

  logic [31:0] q_d;

  always_comb begin
    q_d = q;
    if (wr_en) begin
      if (wdata == 32'hFFFF_FFFF) q_d = SMASK | (q & LOWM);
      else                        q_d = (wdata & ~LOWM) | (q & LOWM);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= RSTV;
    else if (wr_en) q <= q_d;
  end

  p_low_bits_fixed_r8: assert property (@(posedge clk) disable iff (!rst_n)
    ((q & LOWM) == RSTV));

  p_size_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata == 32'hFFFF_FFFF) |=> ((q & ~LOWM) == SMASK));

  p_plain_store_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wdata != 32'hFFFF_FFFF) |=> ((q & ~LOWM) == ($past(wdata) & ~LOWM)));

endmodule

// File: rtl/cfg_rd_mux.sv
module cfg_rd_mux
  import cfg_hdr_pkg::*;
(
  input  logic [HDR_DW*32-1:0] hdr,
  input  logic [5:0]           off,
  input  logic [2:0]           size,
  input  logic                 dev_sel,
  input  logic [31:0]          dev_rdata,
  output logic [31:0]          rdata,
  output logic                 bad_size
);

  logic [3:0]  idx;
  logic [31:0] cur_dw;
  logic [31:0] nxt_dw;
  logic [63:0] pair;
  logic [63:0] shifted;
  logic [31:0] sized;

  assign idx      = off[5:2];
  assign bad_size = !(size == SZ_BYTE || size == SZ_HALF || size == SZ_WORD);

  always_comb begin
    cur_dw = hdr[idx*32 +: 32];
    nxt_dw = (idx == 4'(HDR_DW - 1)) ? 32'h0 : hdr[(idx + 4'd1)*32 +: 32];
    pair    = {nxt_dw, cur_dw};
    shifted = pair >> {off[1:0], 3'b000};
    case (size)
      SZ_BYTE: sized = {24'h0, shifted[7:0]};
      SZ_HALF: sized = {16'h0, shifted[15:0]};
      SZ_WORD: sized = shifted[31:0];
      default: sized = 32'h0;
    endcase
    rdata = dev_sel ? dev_rdata : sized;
  end

  always_comb begin
    if (bad_size && !dev_sel) begin
      a_bad_size_zero_r2: assert (rdata == 32'h0);
    end
  end

endmodule

// File: rtl/cfg_header_regs.sv
module cfg_header_regs
  import cfg_hdr_pkg::*;
#(
  parameter int                       OFF_W      = 8,
  parameter logic [15:0]              VENDOR_ID  = 16'h1A2B,
  parameter logic [15:0]              DEVICE_ID  = 16'h3C4D,
  parameter logic [7:0]               REVISION   = 8'h05,
  parameter logic [23:0]              CLASS_CODE = 24'h010185,
  parameter logic [7:0]               HDR_TYPE   = 8'h00,
  parameter logic [7:0]               INT_PIN    = 8'h01,
  parameter logic [7:0]               MIN_GNT    = 8'h02,
  parameter logic [7:0]               MAX_LAT    = 8'h04,
  parameter logic [NUM_BARS*32-1:0]   BAR_SIZE   = {32'h0, 32'h100, 32'h0,
                                                    32'h0010_0000, 32'h1000, 32'h20},
  parameter logic [NUM_BARS-1:0]      BAR_IO     = 6'b010001
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OFF_W-1:0] cfg_offset,
  input  logic [2:0]       cfg_size,
  input  logic [31:0]      cfg_wdata,
  input  logic             cfg_wr,
  output logic [31:0]      rdata,
  output logic             rd_bad_size,
  output logic             wr_nack,
  output logic             dev_wr,
  output logic [OFF_W-1:0] dev_offset,
  input  logic [31:0]      dev_rdata
);

  localparam logic [NUM_BARS-1:0] BAR_LIVE = bar_live(BAR_SIZE);

  wr_dec_t     dec;
  logic        dev_sel;
  logic [15:0] cmd_q,  cmd_d;
  logic [15:0] stat_q, stat_d;
  logic [7:0]  iline_q, iline_d;
  logic [7:0]  cls_q,  cls_d;
  logic [7:0]  lat_q,  lat_d;
  logic        small_en;
  logic [31:0] bar_q [NUM_BARS];
  logic [HDR_DW*32-1:0] hdr;

  assign dev_sel    = (cfg_offset >= OFF_W'(HDR_END));
  assign dev_wr     = cfg_wr && dev_sel;
  assign dev_offset = cfg_offset - OFF_W'(HDR_END);

  cfg_wr_decode #(
    .OFF_W    (OFF_W),
    .BAR_LIVE (BAR_LIVE)
  ) u_dec (
    .off  (cfg_offset),
    .size (cfg_size),
    .wr   (cfg_wr),
    .dec  (dec)
  );

  // next state for the narrow writable fields
  always_comb begin
    cmd_d   = cmd_q;
    stat_d  = stat_q;
    iline_d = iline_q;
    cls_d   = cls_q;
    lat_d   = lat_q;
    if (dec.cmd)   cmd_d   = cfg_wdata[15:0];
    if (dec.stat)  stat_d  = cfg_wdata[15:0];
    if (dec.iline) iline_d = cfg_wdata[7:0];
    if (dec.cls)   cls_d   = cfg_wdata[7:0];
    if (dec.lat)   lat_d   = cfg_wdata[7:0];
  end

  assign small_en = dec.cmd | dec.stat | dec.iline | dec.cls | dec.lat;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_q   <= 16'h0;
      stat_q  <= 16'h0;
      iline_q <= 8'h0;
      cls_q   <= 8'h0;
      lat_q   <= 8'h0;
    end else if (small_en) begin
      cmd_q   <= cmd_d;
      stat_q  <= stat_d;
      iline_q <= iline_d;
      cls_q   <= cls_d;
      lat_q   <= lat_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_nack <= 1'b0;
    else        wr_nack <= dec.nack;
  end

  for (genvar b = 0; b < NUM_BARS; b++) begin : g_bar
    if (BAR_SIZE[b*32 +: 32] == 32'h0) begin : g_absent
      assign bar_q[b] = 32'h0;
    end else begin : g_present
      cfg_bar_slot #(
        .SIZE  (BAR_SIZE[b*32 +: 32]),
        .IS_IO (BAR_IO[b])
      ) u_slot (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (dec.bar[b]),
        .wdata (cfg_wdata),
        .q     (bar_q[b])
      );
    end
    assign hdr[(4 + b)*32 +: 32] = bar_q[b];
  end

  assign hdr[0*32 +: 32]  = {DEVICE_ID, VENDOR_ID};
  assign hdr[1*32 +: 32]  = {stat_q, cmd_q};
  assign hdr[2*32 +: 32]  = {CLASS_CODE, REVISION};
  assign hdr[3*32 +: 32]  = {8'h00, HDR_TYPE, lat_q, cls_q};
  assign hdr[(4 + NUM_BARS)*32 +: (HDR_DW - 5 - NUM_BARS)*32] = '0;
  assign hdr[(HDR_DW-1)*32 +: 32] = {MAX_LAT, MIN_GNT, INT_PIN, iline_q};

  cfg_rd_mux u_rd (
    .hdr       (hdr),
    .off       (cfg_offset[5:0]),
    .size      (cfg_size),
    .dev_sel   (dev_sel),
    .dev_rdata (dev_rdata),
    .rdata     (rdata),
    .bad_size  (rd_bad_size)
  );

  p_nack_after_write_r12: assert property (@(posedge clk) disable iff (!rst_n)
    wr_nack |-> $past(cfg_wr));

  p_reject_keeps_state_r9: assert property (@(posedge clk) disable iff (!rst_n)
    dec.nack |=> $stable(hdr));

  p_forward_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dev_wr |=> (!wr_nack && $stable(hdr)));

  p_absent_bar_flagged_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_size == SZ_WORD && cfg_offset == OFF_W'(OFF_BAR0 + 12)) |=> wr_nack);

endmodule

// File: tb/cfg_header_regs_bench.sv
`timescale 1ns/100ps
module cfg_header_regs_bench;

  logic        clk;
  logic        rst_n;
  logic [7:0]  cfg_offset;
  logic [2:0]  cfg_size;
  logic [31:0] cfg_wdata;
  logic        cfg_wr;
  logic [31:0] rdata;
  logic        rd_bad_size;
  logic        wr_nack;
  logic        dev_wr;
  logic [7:0]  dev_offset;
  logic [31:0] dev_rdata;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  // bench view of the parameters
  localparam logic [31:0] SZ [6] = '{32'h20, 32'h1000, 32'h0010_0000, 32'h0, 32'h100, 32'h0};
  localparam bit          IO [6] = '{1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};

  // model state
  logic [15:0] m_cmd, m_stat;
  logic [7:0]  m_il, m_cls, m_lat;
  logic [31:0] m_bar [6];

  assign dev_rdata = 32'hA5A5_0000 | {24'h0, dev_offset};

  cfg_header_regs u_cfg_header_regs (
    .clk(clk), .rst_n(rst_n), .cfg_offset(cfg_offset), .cfg_size(cfg_size),
    .cfg_wdata(cfg_wdata), .cfg_wr(cfg_wr), .rdata(rdata), .rd_bad_size(rd_bad_size),
    .wr_nack(wr_nack), .dev_wr(dev_wr), .dev_offset(dev_offset), .dev_rdata(dev_rdata)
  );

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  function automatic logic [31:0] exp_dw(input int i);
    case (i)
      0:  return {16'h3C4D, 16'h1A2B};
      1:  return {m_stat, m_cmd};
      2:  return {24'h010185, 8'h05};
      3:  return {8'h00, 8'h00, m_lat, m_cls};
      4, 5, 6, 7, 8, 9: return m_bar[i-4];
      15: return {8'h04, 8'h02, 8'h01, m_il};
      default: return 32'h0;
    endcase
  endfunction

  function automatic logic [7:0] exp_byte(input int a);
    logic [31:0] d;
    if (a >= 'h40) return 8'h0;
    d = exp_dw(a / 4);
    return d[(a % 4)*8 +: 8];
  endfunction

  function automatic logic [31:0] exp_read(input int off, input int sz);
    logic [31:0] r;
    if (off >= 'h40) return 32'hA5A5_0000 | 32'(off - 'h40);
    if (sz != 1 && sz != 2 && sz != 4) return 32'h0;
    r = 32'h0;
    for (int k = 0; k < sz; k++) r[k*8 +: 8] = exp_byte(off + k);
    return r;
  endfunction

  // returns 1 when the write is flagged; applies it to the model otherwise
  function automatic bit model_write(input int off, input int sz, input logic [31:0] d);
    logic [31:0] low;
    if (off >= 'h40) return 1'b0;
    if (sz == 1) begin
      if (off == 'h3C)      m_il  = d[7:0];
      else if (off == 'h0C) m_cls = d[7:0];
      else if (off == 'h0D) m_lat = d[7:0];
      else return 1'b1;
      return 1'b0;
    end
    if (sz == 2) begin
      if (off == 'h04)      m_cmd  = d[15:0];
      else if (off == 'h06) m_stat = d[15:0];
      else return 1'b1;
      return 1'b0;
    end
    if (sz == 4) begin
      for (int b = 0; b < 6; b++) begin
        if (off == 'h10 + 4*b) begin
          if (SZ[b] == 32'h0) return 1'b1;
          low = IO[b] ? 32'h3 : 32'hF;
          if (d == 32'hFFFF_FFFF) m_bar[b] = (~(SZ[b] - 32'h1) & ~low) | (m_bar[b] & low);
          else                    m_bar[b] = (d & ~low) | (m_bar[b] & low);
          return 1'b0;
        end
      end
      return 1'b1;
    end
    return 1'b1;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd(input int off, input int sz, input string tag);
    @(negedge clk);
    cfg_wr     = 1'b0;
    cfg_offset = 8'(off);
    cfg_size   = 3'(sz);
    #1;
    chk(tag, rdata, exp_read(off, sz));
    if (sz != 1 && sz != 2 && sz != 4) chk({tag, " R2 bad size flag"}, 32'(rd_bad_size), 32'h1);
  endtask

  task automatic wr(input int off, input int sz, input logic [31:0] d, input string tag);
    bit exp_nack;
    @(negedge clk);
    cfg_offset = 8'(off);
    cfg_size   = 3'(sz);
    cfg_wdata  = d;
    cfg_wr     = 1'b1;
    #1;
    if (off >= 'h40) begin
      chk({tag, " R3 dev_wr"}, 32'(dev_wr), 32'h1);
      chk({tag, " R3 dev_offset"}, 32'(dev_offset), 32'(off - 'h40));
    end
    exp_nack = model_write(off, sz, d);
    @(negedge clk);
    cfg_wr = 1'b0;
    chk({tag, " nack R12"}, 32'(wr_nack), 32'(exp_nack));
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240607));
    rst_n = 1'b0; cfg_wr = 1'b0; cfg_offset = 8'h0; cfg_size = 3'd4; cfg_wdata = 32'h0;
    m_cmd = 16'h0; m_stat = 16'h0; m_il = 8'h0; m_cls = 8'h0; m_lat = 8'h0;
    for (int b = 0; b < 6; b++) m_bar[b] = IO[b] ? 32'h1 : 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd('h00, 4, "R1 ids");
    chk("R1 ids literal", rdata, 32'h3C4D_1A2B);
    rd('h08, 4, "R1 class/rev");
    rd('h0E, 1, "R1 header type");
    rd('h3C, 4, "R1 int line/pin/gnt/lat");
    rd('h04, 4, "R1 cmd/status");
    rd('h10, 4, "R1 bar0 io");
    chk("R1 bar0 literal", rdata, 32'h1);
    rd('h14, 4, "R1 bar1 mem");
    chk("R1 nack idle", 32'(wr_nack), 32'h0);

    // R2 widths and edges
    rd('h01, 2, "R2 half unaligned");
    rd('h03, 4, "R2 word across dwords");
    rd('h3E, 4, "R2 word past header end");
    rd('h00, 3, "R2 size3 read");
    rd('h08, 0, "R2 size0 read");

    // R4 / R5 byte writes
    wr('h3C, 1, 32'hFFFF_FF5A, "R4 int line");
    rd('h3C, 1, "R4 int line readback");
    wr('h0C, 1, 32'h10, "R4 cache line");
    wr('h0D, 1, 32'h40, "R4 latency");
    rd('h0C, 2, "R4 cls/lat readback");
    wr('h3D, 1, 32'hEE, "R5 int pin");
    chk("R12 nack drops", 32'(wr_nack), 32'h1);
    @(negedge clk);
    chk("R12 nack one cycle", 32'(wr_nack), 32'h0);
    wr('h3E, 1, 32'hEE, "R5 min gnt");
    wr('h3F, 1, 32'hEE, "R5 max lat");
    wr('h09, 1, 32'hEE, "R5 class code");
    wr('h08, 1, 32'hEE, "R5 revision");
    rd('h3C, 4, "R5 bytes unchanged");
    rd('h08, 4, "R5 class/rev unchanged");

    // R6 halfword writes
    wr('h04, 2, 32'h1234_0147, "R6 command");
    wr('h06, 2, 32'h0000_0290, "R6 status");
    rd('h04, 4, "R6 cmd/status readback");

    // R7 / R8 / R11 BARs
    wr('h10, 4, 32'hFFFF_FFFF, "R7 size io bar0");
    rd('h10, 4, "R7 bar0 mask");
    chk("R7 bar0 literal", rdata, 32'hFFFF_FFE1);
    wr('h14, 4, 32'hFFFF_FFFF, "R7 size mem bar1");
    rd('h14, 4, "R7 bar1 mask");
    chk("R7 bar1 literal", rdata, 32'hFFFF_F000);
    wr('h18, 4, 32'hFFFF_FFFF, "R7 size mem bar2");
    rd('h18, 4, "R7 bar2 mask");
    wr('h20, 4, 32'h1234_567A, "R8 io bar4 store");
    rd('h20, 4, "R8 bar4 readback");
    chk("R8 bar4 literal", rdata, 32'h1234_5679);
    wr('h14, 4, 32'hABCD_EF0F, "R8 mem bar1 store");
    rd('h14, 4, "R8 bar1 low bits kept");
    wr('h1C, 4, 32'hFFFF_FFFF, "R11 absent bar3 size");
    rd('h1C, 4, "R11 bar3 reads zero");
    wr('h24, 4, 32'h8000_0000, "R11 absent bar5");
    rd('h24, 4, "R11 bar5 reads zero");

    // R9 / R10 rejections
    wr('h04, 3, 32'hFFFF_FFFF, "R9 size3 write");
    wr('h0C, 0, 32'hFFFF_FFFF, "R9 size0 write");
    wr('h3C, 5, 32'hFFFF_FFFF, "R9 size5 write");
    wr('h04, 4, 32'hFFFF_FFFF, "R10 word at cmd");
    wr('h3C, 2, 32'hFFFF, "R10 half at int line");
    wr('h12, 4, 32'hFFFF_FFFF, "R10 unaligned bar");
    wr('h00, 2, 32'hFFFF, "R10 half at ids");
    wr('h10, 1, 32'hFF, "R10 byte at bar0");
    rd('h04, 4, "R10 cmd unchanged");
    rd('h10, 4, "R10 bar0 unchanged");
    rd('h0C, 4, "R9 cls unchanged");

    // R3 forwarding
    wr('h40, 4, 32'hDEAD_BEEF, "R3 forward 0x40");
    wr('h7F, 1, 32'h11, "R3 forward 0x7F");
    rd('h44, 4, "R3 forward read");
    rd('hC3, 3, "R3 forward read odd size");

    // random mix
    for (int i = 0; i < 400; i++) begin
      int off, sz, pick;
      logic [31:0] d;
      pick = int'($urandom_range(0, 7));
      case (pick)
        0: sz = 1; 1: sz = 1; 2: sz = 2; 3: sz = 4;
        4: sz = 4; 5: sz = 4; 6: sz = 3; default: sz = 0;
      endcase
      off = int'($urandom_range(0, 'h4F));
      if ($urandom_range(0, 2) == 0) off = off & 'h3C;
      d = ($urandom_range(0, 3) == 0) ? 32'hFFFF_FFFF : $urandom;
      wr(off, sz, d, "R8 random write");
      rd(int'($urandom_range(0, 'h47)), (pick < 6) ? sz : 4, "R2 random read");
    end

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule